// File: doc/BRIEF.md
# Burst Mode Idle Controller

This block paces a group of PWM outputs through repeated bursts. Each burst period has two phases. In the idle phase the outputs are held off. In the run phase the outputs switch normally. A 16-bit burst counter steps once for each pulse of a burst clock enable. It counts from zero up to a programmed period value and then returns to zero. While the counter has not yet passed a programmed compare value, the controller raises an idle flag. The PWM timers use this flag to hold their outputs off. After the compare match, the flag drops until the period ends.

Software programs the block through a small write port. Select 0 writes the compare register and select 1 writes the period register. Select 2 writes a control word: bit 0 enables preload, bit 1 selects single-shot mode, and bit 2 is the run bit. Writing the control word with the run bit set starts or restarts a burst. Writing it with the run bit clear stops the controller.

With preload enabled, compare and period writes are held in shadow copies. Those copies move into the active registers only at a period rollover. With preload disabled, writes land in the active registers at once. Their effect then depends on where the counter stands when the write arrives, and on the operating mode.

Top module: `burst_idle_ctrl`

## Requirements
- R1: After reset the controller is stopped and `idle` is low. The active compare value is 0 and the active period value is 0xFFFF.
- R2: The burst counter advances by one only on clock cycles where `burst_ce` is high while the controller is running. On any other cycle it holds its value.
- R3: In continuous mode, each burst period lasts period+1 counter ticks. For counter values 0 up to and including the compare value, `idle` is high. From compare+1 through the period value, `idle` is low. If the compare value is at or above the period value, the whole period is idle. A counter value that matches both the period and the compare value counts as a rollover.
- R4: In single-shot mode, the controller runs one burst period and then stops with `idle` low. Whenever the controller is stopped, `idle` is low.
- R5: A control write (select 2) with bit 2 set restarts the counter at 0 with `idle` high. The restart loads the shadow compare and period values into the active registers. A control write with bit 2 clear stops the controller and drives `idle` low.
- R6: With preload on (control bit 0 = 1), compare and period writes do not change the current period. They take effect from the next rollover.
- R7: With preload off, a compare value written above the current counter value takes effect in the current period.
- R8: With preload off, a compare value written below the current counter value gives no match in the current period. `idle` stays high until the period ends. In continuous mode the new value applies from the next period. In single-shot mode the controller then stops.
- R9: With preload off, a period value written above the current counter value ends the current period at the new value.
- R10: With preload off, a period value written below the current counter value is passed by the counter. The counter runs on to 0xFFFF and wraps to 0, which counts as a rollover. The new period then applies. In single-shot mode the wrap does not stop the controller: it runs one more period up to the new value and then stops.
- R11: With preload on, a compare or period write that arrives in the same cycle as a rollover takes effect in the period that begins at that rollover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_ce | input | 1 | Burst clock enable; one counter tick per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 compare, 1 period, 2 control |
| wr_data | input | 16 | Write data; control uses bits 0 (preload), 1 (single-shot), 2 (run) |
| idle | output | 1 | High during the idle phase of a running burst period |

## Verification
A register write and a period rollover can land on the same clock edge. With preload on, the shadow register then has to forward the new value into the active register, not the value it held before. The bench provokes this by writing the compare register on the very tick where the counter sits at the period value. It then judges the next period's idle length against the new compare value. A second clash, a compare match on the same tick as a rollover, comes up in the sweep whenever the compare value equals the period. The bench judges it by expecting the next period to open idle.

// File: rtl/bic_pkg.sv
package bic_pkg;

  // register select codes on the write port
  typedef enum logic [1:0] {
    SEL_CMP  = 2'd0,
    SEL_PER  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // bit positions inside the control word
  localparam int unsigned CTRL_PRELOAD = 0;
  localparam int unsigned CTRL_ONESHOT = 1;
  localparam int unsigned CTRL_RUN     = 2;

endpackage

// File: rtl/bic_regs.sv
module bic_regs
  import bic_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rollover,
  output logic [CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0] per_act,
  output logic             preload_en,
  output logic             one_shot,
  output logic             start_evt,
  output logic             stop_evt
);

  localparam logic [CNT_W-1:0] PER_RST = {CNT_W{1'b1}};

  logic             wr_cmp, wr_per, wr_ctrl;
  logic [CNT_W-1:0] cmp_sh, per_sh;
  logic [CNT_W-1:0] cmp_nx, per_nx;
  logic             load_all;

  assign wr_cmp  = wr_en && (wr_sel == SEL_CMP);
  assign wr_per  = wr_en && (wr_sel == SEL_PER);
  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);

  assign start_evt = wr_ctrl &&  wr_data[CTRL_RUN];
  assign stop_evt  = wr_ctrl && !wr_data[CTRL_RUN];

  // a write in the same cycle as a transfer is forwarded into the transfer
  function automatic logic [CNT_W-1:0] f_merge(input logic             hit,
                                                input logic [CNT_W-1:0] fresh,
                                                input logic [CNT_W-1:0] held);
    return hit ? fresh : held;
  endfunction

  assign cmp_nx   = f_merge(wr_cmp, wr_data, cmp_sh);
  assign per_nx   = f_merge(wr_per, wr_data, per_sh);
  assign load_all = start_evt || rollover;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_sh     <= '0;
      per_sh     <= PER_RST;
      cmp_act    <= '0;
      per_act    <= PER_RST;
      preload_en <= 1'b0;
      one_shot   <= 1'b0;
    end else begin
      cmp_sh <= cmp_nx;
      per_sh <= per_nx;
      if (wr_ctrl) begin
        preload_en <= wr_data[CTRL_PRELOAD];
        one_shot   <= wr_data[CTRL_ONESHOT];
      end
      if (load_all) begin
        cmp_act <= cmp_nx;
        per_act <= per_nx;
      end else if (!preload_en) begin
        if (wr_cmp) cmp_act <= wr_data;
        if (wr_per) per_act <= wr_data;
      end
    end
  end

endmodule

// File: rtl/bic_counter.sv
module bic_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_ce,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             one_shot,
  input  logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             tick,
  output logic             period_end,
  output logic             wrap_evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // next count: back to zero on the period value or at the top of the range
  function automatic logic [CNT_W-1:0] f_advance(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] p);
    if (c == p || c == CNT_MAX) return '0;
    return c + 1'b1;
  endfunction

  assign tick       = burst_ce && running;
  assign period_end = tick && (cnt == per_act);
  assign wrap_evt   = tick && (cnt != per_act) && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start_evt) begin
      cnt     <= '0;
      running <= 1'b1;
    end else if (stop_evt) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (tick) begin
      cnt <= f_advance(cnt, per_act);
      if (period_end && one_shot) running <= 1'b0;
    end
  end

endmodule

// File: rtl/bic_phase.sv
module bic_phase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             running,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_act,
  input  logic             rollover,
  input  logic             start_evt,
  input  logic             stop_evt,
  output logic             match_evt,
  output logic             idle
);

  logic matched;

  // a rollover on the same tick takes priority over the match
  assign match_evt = tick && (cnt == cmp_act) && !rollover;
  assign idle      = running && !matched;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      matched <= 1'b0;
    end else if (start_evt || stop_evt || rollover) begin
      matched <= 1'b0;
    end else if (match_evt) begin
      matched <= 1'b1;
    end
  end

endmodule

// File: rtl/burst_idle_ctrl.sv
module burst_idle_ctrl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_ce,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             idle
);

  logic [CNT_W-1:0] cmp_act, per_act, cnt;
  logic             preload_en, one_shot, start_evt, stop_evt;
  logic             running, tick, period_end, wrap_evt, rollover, match_evt;

  assign rollover = period_end || wrap_evt;

  bic_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rollover   (rollover),
    .cmp_act    (cmp_act),
    .per_act    (per_act),
    .preload_en (preload_en),
    .one_shot   (one_shot),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt)
  );

  bic_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_ce   (burst_ce),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .one_shot   (one_shot),
    .per_act    (per_act),
    .cnt        (cnt),
    .running    (running),
    .tick       (tick),
    .period_end (period_end),
    .wrap_evt   (wrap_evt)
  );

  bic_phase #(.CNT_W(CNT_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .running   (running),
    .cnt       (cnt),
    .cmp_act   (cmp_act),
    .rollover  (rollover),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .match_evt (match_evt),
    .idle      (idle)
  );

endmodule

// File: rtl/bic_checker.sv
module bic_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_ce,
  input logic             wr_en,
  input logic [CNT_W-1:0] cnt,
  input logic             running,
  input logic             one_shot,
  input logic             preload_en,
  input logic             period_end,
  input logic             wrap_evt,
  input logic             rollover,
  input logic             match_evt,
  input logic             start_evt,
  input logic             stop_evt,
  input logic [CNT_W-1:0] cmp_act,
  input logic [CNT_W-1:0] per_act,
  input logic             idle
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_ce && !wr_en) |=> $stable(cnt));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_ce && running && !rollover && !wr_en) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !start_evt && !stop_evt) |=> !idle);

  p_oneshot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && one_shot && !start_evt && !stop_evt) |=> (!running && !idle));

  p_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !idle);

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (cnt == '0 && idle));

  p_preload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && !rollover && !start_evt) |=> ($stable(cmp_act) && $stable(per_act)));

  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !start_evt && !stop_evt) |=> (cnt == '0 && running && idle));

endmodule

bind burst_idle_ctrl bic_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .burst_ce   (burst_ce),
  .wr_en      (wr_en),
  .cnt        (cnt),
  .running    (running),
  .one_shot   (one_shot),
  .preload_en (preload_en),
  .period_end (period_end),
  .wrap_evt   (wrap_evt),
  .rollover   (rollover),
  .match_evt  (match_evt),
  .start_evt  (start_evt),
  .stop_evt   (stop_evt),
  .cmp_act    (cmp_act),
  .per_act    (per_act),
  .idle       (idle)
);

// File: tb/sim_burst_idle_ctrl.sv
module sim_burst_idle_ctrl;

  localparam logic [1:0] S_CMP = 2'd0, S_PER = 2'd1, S_CTRL = 2'd2;
  // control word: bit0 preload, bit1 single-shot, bit2 run
  localparam logic [15:0] C_CONT    = 16'h0004;
  localparam logic [15:0] C_CONT_PL = 16'h0005;
  localparam logic [15:0] C_ONE     = 16'h0006;
  localparam logic [15:0] C_ONE_PL  = 16'h0007;
  localparam logic [15:0] C_STOP    = 16'h0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst_ce = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        idle;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  burst_idle_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .burst_ce(burst_ce), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .idle(idle)
  );

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (idle !== exp) begin
      n_err++;
      $display("FAIL %s: idle=%0b expected %0b at %0t", tag, idle, exp, $time);
    end
  endtask

  // drive one edge, then return after the following falling edge
  task automatic step(input logic ce, input logic we, input logic [1:0] sel,
                      input logic [15:0] d);
    burst_ce = ce; wr_en = we; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick1();
    step(1'b1, 1'b0, 2'd0, 16'd0);
  endtask

  task automatic start(input int p, input int c, input logic [15:0] ctl);
    step(1'b0, 1'b1, S_PER, 16'(p));
    step(1'b0, 1'b1, S_CMP, 16'(c));
    step(1'b1, 1'b1, S_CTRL, ctl);
  endtask

  // check idle == (v <= c) for visible counts lo..hi, one tick each
  task automatic seq(input int lo, input int hi, input int c, input string tag);
    for (int v = lo; v <= hi; v++) begin
      check(v <= c, tag);
      tick1();
    end
  endtask

  task automatic wrap_case(input logic [15:0] ctl, input string tag);
    int bad;
    start(10, 2, ctl);
    seq(0, 5, 2, tag);
    step(1'b1, 1'b1, S_PER, 16'd3);          // visible count is now 7
    bad = 0;
    for (int n = 0; n < 65529; n++) begin
      if (idle !== 1'b0) bad++;
      tick1();
    end
    n_chk++;
    if (bad != 0) begin
      n_err++;
      $display("FAIL %s: idle high on %0d ticks before wrap, expected 0", tag, bad);
    end
    seq(0, 3, 2, tag);                        // one period up to the new value
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(1'b0, "R1 in reset");
    step(1'b1, 1'b0, 2'd0, 16'd0);
    rst_n = 1'b1;
    repeat (3) tick1();
    check(1'b0, "R1 after reset, not started");

    // R3 sweep, continuous mode
    for (int p = 0; p <= 6; p++)
      for (int c = 0; c <= 7; c++) begin
        start(p, c, C_CONT_PL);
        for (int k = 0; k < 3 * (p + 1); k++) begin
          check((k % (p + 1)) <= c, "R3 continuous sweep");
          tick1();
        end
      end

    // R4 sweep, single-shot mode
    for (int p = 0; p <= 5; p++)
      for (int c = 0; c <= 6; c++) begin
        start(p, c, C_ONE_PL);
        for (int k = 0; k < p + 4; k++) begin
          check((k <= p) && (k <= c), "R4 single-shot sweep");
          tick1();
        end
      end

    // R2 gated enable: one tick every third cycle
    begin
      int ncnt;
      start(4, 1, C_CONT);
      ncnt = 0;
      for (int i = 0; i < 60; i++) begin
        check((ncnt % 5) <= 1, "R2 gated enable");
        step(i % 3 == 0, 1'b0, 2'd0, 16'd0);
        if (i % 3 == 0) ncnt++;
      end
    end

    // R5 stop and restart
    start(8, 4, C_CONT);
    seq(0, 6, 4, "R5 before stop");
    step(1'b1, 1'b1, S_CTRL, C_STOP);
    for (int i = 0; i < 4; i++) begin check(1'b0, "R5 stopped"); tick1(); end
    start(8, 4, C_CONT);
    seq(0, 5, 4, "R5 run");
    step(1'b1, 1'b1, S_CTRL, C_CONT);         // restart mid-period
    seq(0, 8, 4, "R5 restart");
    seq(0, 2, 4, "R5 restart");

    // R6 preload on: writes wait for rollover
    start(10, 2, C_CONT_PL);
    seq(0, 0, 2, "R6");
    step(1'b1, 1'b1, S_CMP, 16'd6);           // at count 1
    step(1'b1, 1'b1, S_PER, 16'd7);           // at count 2
    seq(3, 10, 2, "R6 current period unchanged");
    seq(0, 7, 6, "R6 next period");
    seq(0, 1, 6, "R6 next period");

    // R11 preload write on the rollover tick
    start(4, 1, C_CONT_PL);
    seq(0, 3, 1, "R11");
    step(1'b1, 1'b1, S_CMP, 16'd3);           // at count 4 = period
    seq(0, 4, 3, "R11 write at rollover");

    // R7 compare written above counter, preload off
    start(10, 2, C_CONT);
    seq(0, 0, 2, "R7");
    step(1'b1, 1'b1, S_CMP, 16'd6);
    seq(2, 10, 6, "R7 current period");
    check(1'b1, "R7 next period start");

    // R8 compare written below counter, continuous
    start(10, 8, C_CONT);
    seq(0, 4, 8, "R8");
    step(1'b1, 1'b1, S_CMP, 16'd3);
    seq(6, 10, 10, "R8 continuous idle to end");
    seq(0, 10, 3, "R8 continuous next period");

    // R8 single-shot
    start(10, 8, C_ONE);
    seq(0, 4, 8, "R8");
    step(1'b1, 1'b1, S_CMP, 16'd3);
    seq(6, 10, 10, "R8 single-shot idle to end");
    for (int i = 0; i < 3; i++) begin check(1'b0, "R8 single-shot stopped"); tick1(); end

    // R9 period written above counter
    start(5, 2, C_CONT);
    seq(0, 2, 2, "R9");
    step(1'b1, 1'b1, S_PER, 16'd9);
    seq(4, 9, 2, "R9 extended period");
    seq(0, 9, 2, "R9 next period");

    // R10 period written below counter: wrap through the top
    wrap_case(C_CONT, "R10 continuous");
    seq(0, 3, 2, "R10 continuous new period");
    wrap_case(C_ONE, "R10 single-shot");
    for (int i = 0; i < 3; i++) begin check(1'b0, "R10 single-shot stopped"); tick1(); end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule